// File: doc/BRIEF.md
# Connection Memory Bulk Fill Engine

This block owns a 512-word, 16-bit connection memory and two host registers: a control word and a mode word. Software can write one word at a time over a valid/ready port. The block can also load the whole memory with a single pattern. Each word then holds a 5-bit value in its top five bits, and its eleven lower bits are cleared.

To run a bulk fill, the host first sets the arm bit in the control word. It then writes the mode word with the 5-bit pattern and the enable bit set, in the same write. The engine waits for the next frame pulse. It writes 256 words, one per clock, in ascending address order. At the following frame pulse it writes the remaining 256 words. When the last word is written, the engine clears the enable bit itself. If the host clears either bit while the engine is busy, the fill stops at once and the enable bit reads 0.

The per-word write port follows these back-pressure rules. A write is accepted on a clock edge where `cm_wr_valid` and `cm_wr_ready` are both high. The host holds valid, address and data until that edge. `cm_wr_ready` is low for as long as the engine is busy. The frame period must be at least 257 clocks.

Top module: `cm_bulk_fill`

## Requirements
- R1: After reset, `ctrl_q` and `mode_q` read 0, `busy` is low and `cm_wr_ready` is high.
- R2: A fill starts only from a mode write (`cfg_sel`=1) that sets bit 4 (enable) while the stored enable bit is 0 and control bit 5 (arm) is already 1. A write that sets enable while arm is 0 does not start a fill. Setting arm later, with enable already 1, does not start one either.
- R3: `busy` is high from the clock edge that takes the starting write. The first frame pulse sampled after that edge begins the fill, and word k is written on the (k+1)-th edge after the pulse edge.
- R4: Every word the engine writes holds mode bits 9..5, captured from the starting write, in its bits 15..11, and 0 in bits 10..0.
- R5: The fill is split into two bursts of 256 words in ascending address order. Words 0..255 follow the first frame pulse, and words 256..511 follow the next frame pulse. No word is written in the gap between the two bursts.
- R6: On the edge that writes word 511, `busy` falls and mode bit 4 clears. All other mode bits keep their written values.
- R7: A write that clears the enable bit or the arm bit while `busy` is high stops the fill on that same edge. Words already written keep the pattern, unwritten words keep their old contents, and mode bit 4 reads 0 afterwards.
- R8: While `busy` is high, `cm_wr_ready` is low and no host write reaches the memory. When `busy` is low, an accepted host write stores its data.
- R9: `cm_rd_data` shows the word at `cm_rd_addr` one clock after the address is sampled.
- R10: Frame pulses while the engine is idle do not change the memory or `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame | input | 1 | Frame start pulse, one clock wide |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = control, 1 = mode |
| cfg_wdata | input | 16 | Register write data |
| ctrl_q | output | 16 | Control register contents (bit 5 = arm) |
| mode_q | output | 16 | Mode register contents (bits 9..5 = pattern, bit 4 = enable) |
| cm_wr_valid | input | 1 | Host word write request |
| cm_wr_ready | output | 1 | Host word write can be accepted |
| cm_wr_addr | input | 9 | Host word write address |
| cm_wr_data | input | 16 | Host word write data |
| cm_rd_addr | input | 9 | Read address |
| cm_rd_data | output | 16 | Read data, one clock latency |
| busy | output | 1 | Fill armed, waiting or running |

## Verification
Each result of this block has a fixed delay. `busy` rises on the edge that takes the enable write. A word written on edge f+k+1, where f is the edge that sampled the frame pulse, can be read back two edges later. `busy` falls and the enable bit clears on edge g+256 of the second burst. An abort takes effect on the edge that takes the clearing write. The bench drives every input on a falling edge and counts falling edges from the frame pulse. It places an abort between a known last written word and the first word left unwritten, and it checks `busy` one cycle before and at the cycle of completion.

// File: rtl/cmbf_pkg.sv
package cmbf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_FILL = 2'd2,
    ST_GAP  = 2'd3
  } fill_st_t;
endpackage

// File: rtl/cmbf_regs.sv
module cmbf_regs #(
  parameter int DATA_W  = 16,
  parameter int PAT_W   = 5,
  parameter int ARM_BIT = 5,
  parameter int EN_BIT  = 4,
  parameter int PAT_LSB = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              en_clr,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] mode_q,
  output logic              keep_run,
  output logic              start,
  output logic [PAT_W-1:0]  pat_in
);
  logic [DATA_W-1:0] ctrl_r, mode_r;
  logic wr_ctrl, wr_mode, arm_nxt, en_nxt;

  assign wr_ctrl = cfg_wr & ~cfg_sel;
  assign wr_mode = cfg_wr & cfg_sel;

  // values the bits take after this edge, before any engine clear
  assign arm_nxt  = wr_ctrl ? cfg_wdata[ARM_BIT] : ctrl_r[ARM_BIT];
  assign en_nxt   = wr_mode ? cfg_wdata[EN_BIT]  : mode_r[EN_BIT];
  assign keep_run = arm_nxt & en_nxt;

  // rising edge of enable, only while armed
  assign start  = wr_mode & cfg_wdata[EN_BIT] & ~mode_r[EN_BIT] & ctrl_r[ARM_BIT];
  assign pat_in = cfg_wdata[PAT_LSB +: PAT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      mode_r <= '0;
    end else begin
      if (wr_ctrl) ctrl_r <= cfg_wdata;
      if (wr_mode) mode_r <= cfg_wdata;
      if (en_clr)  mode_r[EN_BIT] <= 1'b0;
    end
  end

  assign ctrl_q = ctrl_r;
  assign mode_q = mode_r;
endmodule

// File: rtl/cmbf_seq.sv
module cmbf_seq
  import cmbf_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  parameter int PAT_W  = 5,
  parameter int PHASES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAT_W-1:0]  pat_in,
  input  logic              keep_run,
  input  logic              frame,
  output logic              busy,
  output logic              eng_we,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [DATA_W-1:0] eng_wdata,
  output logic              en_clr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PER   = DEPTH / PHASES;
  localparam int PER_W = $clog2(PER);

  fill_st_t          st;
  logic [ADDR_W-1:0] addr_q;
  logic [PAT_W-1:0]  pat_q;
  logic abort, last_burst, last_all, done;

  assign busy       = (st != ST_IDLE);
  assign abort      = busy & ~keep_run;
  assign last_burst = (addr_q[PER_W-1:0] == {PER_W{1'b1}});
  assign last_all   = (addr_q == {ADDR_W{1'b1}});
  assign eng_we     = (st == ST_FILL) & ~abort;
  assign done       = eng_we & last_all;
  assign en_clr     = abort | done;
  assign eng_addr   = addr_q;
  assign eng_wdata  = {pat_q, {(DATA_W-PAT_W){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      pat_q  <= '0;
    end else if (abort) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st     <= ST_PEND;
          addr_q <= '0;
          pat_q  <= pat_in;
        end
        ST_PEND: if (frame) st <= ST_FILL;
        ST_FILL: begin
          addr_q <= addr_q + 1'b1;
          if (last_all)        st <= ST_IDLE;
          else if (last_burst) st <= ST_GAP;
        end
        ST_GAP:  if (frame) st <= ST_FILL;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmbf_mem.sv
module cmbf_mem #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              eng_we,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  // engine port wins over host port
  always_ff @(posedge clk) begin
    if (eng_we)       mem[eng_addr]  <= eng_wdata;
    else if (host_we) mem[host_addr] <= host_wdata;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cm_bulk_fill.sv
module cm_bulk_fill #(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 16,
  parameter int PAT_W   = 5,
  parameter int PHASES  = 2,
  parameter int ARM_BIT = 5,
  parameter int EN_BIT  = 4,
  parameter int PAT_LSB = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] mode_q,
  input  logic              cm_wr_valid,
  output logic              cm_wr_ready,
  input  logic [ADDR_W-1:0] cm_wr_addr,
  input  logic [DATA_W-1:0] cm_wr_data,
  input  logic [ADDR_W-1:0] cm_rd_addr,
  output logic [DATA_W-1:0] cm_rd_data,
  output logic              busy
);
  logic              keep_run, start, en_clr, eng_we, host_we;
  logic [PAT_W-1:0]  pat_in;
  logic [ADDR_W-1:0] eng_addr;
  logic [DATA_W-1:0] eng_wdata;

  cmbf_regs #(
    .DATA_W(DATA_W), .PAT_W(PAT_W), .ARM_BIT(ARM_BIT),
    .EN_BIT(EN_BIT), .PAT_LSB(PAT_LSB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .en_clr(en_clr), .ctrl_q(ctrl_q),
    .mode_q(mode_q), .keep_run(keep_run), .start(start), .pat_in(pat_in)
  );

  cmbf_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_W(PAT_W), .PHASES(PHASES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_in(pat_in),
    .keep_run(keep_run), .frame(frame), .busy(busy), .eng_we(eng_we),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata), .en_clr(en_clr)
  );

  assign cm_wr_ready = ~busy;
  assign host_we     = cm_wr_valid & cm_wr_ready;

  cmbf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .host_we(host_we), .host_addr(cm_wr_addr), .host_wdata(cm_wr_data),
    .rd_addr(cm_rd_addr), .rd_data(cm_rd_data)
  );
endmodule

// File: rtl/cmbf_sva.sv
module cmbf_sva #(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 16,
  parameter int PAT_W   = 5,
  parameter int PHASES  = 2,
  parameter int ARM_BIT = 5,
  parameter int EN_BIT  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              cfg_sel,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] mode_q,
  input logic              busy,
  input logic              eng_we,
  input logic              host_we,
  input logic [ADDR_W-1:0] eng_addr,
  input logic [DATA_W-1:0] eng_wdata
);
  localparam int PER_W = $clog2((1 << ADDR_W) / PHASES);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_wr && cfg_sel && cfg_wdata[EN_BIT]
                          && ctrl_q[ARM_BIT] && !mode_q[EN_BIT]));

  p_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> (eng_wdata[DATA_W-PAT_W-1:0] == '0));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && eng_addr[PER_W-1:0] != {PER_W{1'b1}})
      |=> (!eng_we || eng_addr == ADDR_W'($past(eng_addr) + 1'b1)));

  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !mode_q[EN_BIT]);

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> (ctrl_q[ARM_BIT] && mode_q[EN_BIT]));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_we && host_we));
endmodule

bind cm_bulk_fill cmbf_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_W(PAT_W), .PHASES(PHASES),
  .ARM_BIT(ARM_BIT), .EN_BIT(EN_BIT)
) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q), .mode_q(mode_q), .busy(busy),
  .eng_we(eng_we), .host_we(host_we), .eng_addr(eng_addr),
  .eng_wdata(eng_wdata)
);

// File: tb/cm_bulk_fill_tb.sv
module cm_bulk_fill_tb;
  logic        clk = 1'b0;
  logic        rst_n, frame, cfg_wr, cfg_sel, cm_wr_valid;
  logic [15:0] cfg_wdata, cm_wr_data, ctrl_q, mode_q, cm_rd_data;
  logic [8:0]  cm_wr_addr, cm_rd_addr;
  logic        cm_wr_ready, busy;
  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [4:0] PA = 5'h13, PB = 5'h0A, PC = 5'h1F;

  always #2 clk = ~clk;

  cm_bulk_fill u_dut (
    .clk(clk), .rst_n(rst_n), .frame(frame), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q),
    .mode_q(mode_q), .cm_wr_valid(cm_wr_valid), .cm_wr_ready(cm_wr_ready),
    .cm_wr_addr(cm_wr_addr), .cm_wr_data(cm_wr_data),
    .cm_rd_addr(cm_rd_addr), .cm_rd_data(cm_rd_data), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all drive tasks start and end on a falling edge
  task automatic reg_wr(input logic sel, input logic [15:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_frame();
    frame = 1'b1;
    @(negedge clk);
    frame = 1'b0;
  endtask

  task automatic host_wr(input logic [8:0] a, input logic [15:0] d);
    cm_wr_valid = 1'b1; cm_wr_addr = a; cm_wr_data = d;
    @(negedge clk);
    cm_wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [15:0] d);
    cm_rd_addr = a;
    @(negedge clk);
    d = cm_rd_data;
  endtask

  function automatic logic [15:0] mode_word(input logic [4:0] p, input logic en);
    return {6'b0, p, en, 4'b0};
  endfunction

  task automatic t_reset();
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 mode", mode_q, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ready", cm_wr_ready, 1);
  endtask

  task automatic t_host();
    logic [15:0] d;
    host_wr(9'd256, 16'hBEEF);
    host_wr(9'd300, 16'h1234);
    host_wr(9'd7, 16'h0A0A);
    rd(9'd256, d); chk("R8/R9 word256", d, 16'hBEEF);
    rd(9'd300, d); chk("R8/R9 word300", d, 16'h1234);
    rd(9'd7, d);   chk("R8/R9 word7", d, 16'h0A0A);
  endtask

  task automatic t_no_arm();
    logic [15:0] d;
    reg_wr(1'b1, mode_word(PA, 1'b1));
    chk("R2 no start unarmed", busy, 0);
    pulse_frame();
    repeat (300) @(negedge clk);
    rd(9'd7, d); chk("R2 memory untouched", d, 16'h0A0A);
    reg_wr(1'b0, 16'h0020);
    chk("R2 arm on level enable", busy, 0);
    reg_wr(1'b1, mode_word(PA, 1'b0));
  endtask

  task automatic t_fill();
    logic [15:0] d;
    int bad = 0;
    reg_wr(1'b1, mode_word(PA, 1'b1));
    chk("R3 busy after start", busy, 1);
    cm_wr_valid = 1'b1; cm_wr_addr = 9'd7; cm_wr_data = 16'h0;
    for (int i = 0; i < 3; i++) begin
      chk("R8 ready low while busy", cm_wr_ready, 0);
      @(negedge clk);
    end
    cm_wr_valid = 1'b0;
    pulse_frame();
    repeat (256) @(negedge clk);
    chk("R5 busy in gap", busy, 1);
    rd(9'd255, d); chk("R3 word255 first burst", d, {PA, 11'b0});
    rd(9'd256, d); chk("R5 word256 waits", d, 16'hBEEF);
    pulse_frame();
    repeat (255) @(negedge clk);
    chk("R5 busy before last", busy, 1);
    @(negedge clk);
    chk("R6 busy done", busy, 0);
    chk("R6 enable cleared", mode_q, mode_word(PA, 1'b0));
    for (int a = 0; a < 512; a++) begin
      rd(a[8:0], d);
      if (d !== {PA, 11'b0}) bad++;
    end
    chk("R4 all words patterned", bad, 0);
  endtask

  task automatic t_abort_en();
    logic [15:0] d;
    reg_wr(1'b1, mode_word(PB, 1'b1));
    pulse_frame();
    repeat (100) @(negedge clk);
    reg_wr(1'b1, mode_word(PB, 1'b0));
    chk("R7 busy after enable clear", busy, 0);
    chk("R7 mode after abort", mode_q, mode_word(PB, 1'b0));
    rd(9'd0, d);   chk("R3 word0", d, {PB, 11'b0});
    rd(9'd99, d);  chk("R7 last written", d, {PB, 11'b0});
    rd(9'd100, d); chk("R7 first unwritten", d, {PA, 11'b0});
  endtask

  task automatic t_abort_arm();
    logic [15:0] d;
    reg_wr(1'b1, mode_word(PC, 1'b1));
    pulse_frame();
    repeat (256) @(negedge clk);
    pulse_frame();
    repeat (10) @(negedge clk);
    reg_wr(1'b0, 16'h0000);
    chk("R7 busy after arm clear", busy, 0);
    chk("R7 enable reads 0", mode_q, mode_word(PC, 1'b0));
    rd(9'd255, d); chk("R5 first burst kept", d, {PC, 11'b0});
    rd(9'd265, d); chk("R7 last written 2nd", d, {PC, 11'b0});
    rd(9'd266, d); chk("R7 unwritten 2nd", d, {PA, 11'b0});
  endtask

  task automatic t_idle_frame();
    logic [15:0] d;
    reg_wr(1'b0, 16'h0020);
    host_wr(9'd300, 16'h5555);
    pulse_frame();
    repeat (300) @(negedge clk);
    chk("R10 busy idle", busy, 0);
    rd(9'd300, d); chk("R10 memory idle", d, 16'h5555);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0;
    cfg_wdata = '0; cm_wr_valid = 1'b0; cm_wr_addr = '0;
    cm_wr_data = '0; cm_rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_host();
    t_no_arm();
    t_fill();
    t_abort_en();
    t_abort_arm();
    t_idle_frame();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule